// File: doc/BRIEF.md
# Buffered Serial Port with Automatic Flow Control

This block is an asynchronous serial transmitter and receiver. Each direction is buffered by a 16-entry queue. Software, or a neighbouring controller, pushes bytes through a write strobe and pops received bytes through a read strobe. The received byte at the head of the queue stays visible on the read port, together with the framing and parity error flags captured for that byte.

Bit timing comes from a 16x oversampling tick. The tick has an integer clock divisor and a fractional stage that lengthens some tick periods by one clock, so the average rate can fall between two integer divisors.

The receive queue level is compared against a selectable threshold. That comparison drives an interrupt line and, when enabled, the request-to-send output, which tells the far end to pause. When clear-to-send gating is enabled, the transmitter holds back new characters while the far end signals it is not ready.

Top module: `fifo_uart`

## Requirements
- R1: After reset, `txd` is high, `rts_n` is low, both queues are empty (`tx_empty`=1, `rx_empty`=1, `rx_level`=0), and `tx_overflow`, `rx_overrun` and `irq_rx` are 0.
- R2: The transmit queue holds 16 bytes. A write while `tx_full` is 1 is ignored and sets the sticky `tx_overflow` flag.
- R3: The receive queue holds 16 entries. A character that completes while the queue is full is discarded, leaves `rx_level` at 16, and sets the sticky `rx_overrun` flag.
- R4: A character on `txd` has this layout:
  - a low start bit;
  - 8 data bits, least significant first;
  - when `cfg_parity_en`=1, one parity bit: the XOR of the data bits for even parity, or its inverse when `cfg_parity_odd`=1;
  - a high stop bit.
  
  Each bit lasts 16 ticks.
- R5: A tick period is `cfg_div` clocks, with 0 treated as 1. When 0 < `cfg_frac_add` < `cfg_frac_mul`, `cfg_frac_add` out of every `cfg_frac_mul` periods are one clock longer. Otherwise no period is lengthened. Examples: div=2, add=1, mul=2 gives a 40-clock start bit; div=3 gives 48.
- R6: `cfg_trig` selects the receive threshold: 00 = 1, 01 = 4, 10 = 8, 11 = 14 entries. `irq_rx` is 1 exactly while `rx_level` is at or above the threshold.
- R7: With `cfg_auto_rts`=1, `rts_n` goes high one clock after `rx_level` reaches the threshold, and returns low one clock after `rx_level` falls below it. With `cfg_auto_rts`=0, `rts_n` stays low.
- R8: With `cfg_auto_cts`=1, no new character starts while the synchronised `cts_n` is high. A character that has already started still completes.
- R9: The receiver samples a detected start bit 8 ticks after detecting it. If the line is high at that point, the start is dropped and no byte is stored. The line must have been seen high before a new start is accepted.
- R10: A stop bit sampled low stores `rd_frame_err`=1 with that byte. When parity is enabled, a parity bit that does not match the R4 rule stores `rd_parity_err`=1.
- R11: `rd_data` shows the oldest received byte, and `rd_en` removes it. Bytes leave in arrival order, and `rd_en` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Pop the head of the receive queue |
| rd_data | output | 8 | Head byte of the receive queue |
| rd_frame_err | output | 1 | Framing error stored with the head byte |
| rd_parity_err | output | 1 | Parity error stored with the head byte |
| cfg_div | input | 16 | Integer clocks per tick |
| cfg_frac_add | input | 4 | Number of lengthened periods per group |
| cfg_frac_mul | input | 4 | Group size of the fractional stage |
| cfg_trig | input | 2 | Receive threshold code |
| cfg_parity_en | input | 1 | Add and check a parity bit |
| cfg_parity_odd | input | 1 | Select odd parity |
| cfg_auto_cts | input | 1 | Gate new characters with `cts_n` |
| cfg_auto_rts | input | 1 | Drive `rts_n` from the receive level |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rts_n | output | 1 | Request to send, active low |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty (a character in flight is not counted) |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 5 | Receive queue fill level |
| tx_overflow | output | 1 | Sticky: a write was refused |
| rx_overrun | output | 1 | Sticky: a received byte was dropped |
| irq_rx | output | 1 | Receive level at or above the threshold |

## Verification
The tick-spacing check assumes that `cfg_div` and the fractional fields stay fixed while a period is counting. The bench therefore changes them only while the transmitter and receiver are idle. The receiver checks assume that `rxd` and `cts_n` change no faster than the two-flop synchronisers can follow. Driven frames hold each level for a full bit time, and the only short pulse applied is the deliberate four-clock glitch. Loopback from `txd` to `rxd` is used only at matching configuration, so the received frames come from the transmitter rules already checked on the wire.

// File: rtl/fifo_uart_pkg.sv
// Shared constants, state encoding and threshold decoding for the serial port.
package fifo_uart_pkg;

    localparam int OSR = 16;  // ticks per serial bit

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } ser_state_t;

    // Maps the two-bit threshold code to a queue level.
    function automatic int unsigned trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/fu_baud.sv
// Oversampling tick generator.
// Emits a one-clock tick every div clocks (0 treated as 1). When 0 < add < mul,
// an accumulator lengthens add out of every mul periods by one clock.
// Assumes the configuration is changed only while the port is idle.
module fu_baud #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic [FRAC_W-1:0] frac_add,
    input  logic [FRAC_W-1:0] frac_mul,
    output logic              tick
);
    logic [DIV_W:0]   cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]  acc_sum;
    logic [DIV_W-1:0] div_eff;
    logic             frac_on;
    logic             ext;

    // Decode the effective divisor and whether this period is lengthened.
    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        frac_on = (frac_add != '0) && (frac_add < frac_mul);
        acc_sum = (FRAC_W+1)'(acc) + (FRAC_W+1)'(frac_add);
        ext     = frac_on && (acc_sum >= (FRAC_W+1)'(frac_mul));
        tick    = (cnt == '0);
    end

    // Count the period down and advance the fractional accumulator on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            acc <= '0;
        end else if (tick) begin
            cnt <= (DIV_W+1)'(div_eff) - (DIV_W+1)'(1) + (DIV_W+1)'(ext);
            if (!frac_on)
                acc <= '0;
            else if (ext)
                acc <= FRAC_W'(acc_sum - (FRAC_W+1)'(frac_mul));
            else
                acc <= FRAC_W'(acc_sum);
        end else begin
            cnt <= cnt - (DIV_W+1)'(1);
        end
    end

    // R5: back-to-back ticks only when the period was a single clock.
    a_r5_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || ($past(div_eff) == DIV_W'(1) && !$past(ext))));

endmodule

// File: rtl/fu_fifo.sv
// Synchronous queue with show-ahead head output.
// A push while full and a pop while empty are ignored. The drop output flags a
// refused push. Storage is not reset; only pointers and level are.
module fu_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    level,
    output logic             drop
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    // Status and accepted-operation decode.
    always_comb begin
        full    = (level == CW'(DEPTH));
        empty   = (level == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        drop    = push && full;
        head    = mem[rptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointer and level bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            level <= level + CW'(do_push) - CW'(do_pop);
        end
    end

    // R2: the level never exceeds the capacity.
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    // R3: a refused push without a pop leaves the level untouched.
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == $past(level)));

endmodule

// File: rtl/fu_tx.sv
// Serial transmitter. Pops a byte on a tick when the queue is non-empty and
// the clear-to-send gate is open, then shifts start, data (LSB first), optional
// parity and stop, each for OSR ticks. A gate closing mid-character is ignored.
module fu_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_data,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              cts_block,
    output logic              q_pop,
    output logic              txd,
    output logic              busy
);
    import fifo_uart_pkg::*;
    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);

    ser_state_t        state;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              bit_end;

    // Launch decode and line level for the current state.
    always_comb begin
        bit_end = tick && (tcnt == TW'(OSR - 1));
        q_pop   = (state == ST_IDLE) && tick && !q_empty && !cts_block;
        busy    = (state != ST_IDLE);
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    // Character sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (state == ST_IDLE) begin
            tcnt <= '0;
            bidx <= '0;
            if (q_pop) begin
                state   <= ST_START;
                shreg   <= q_data;
                par_bit <= (^q_data) ^ par_odd;
            end
        end else if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + TW'(1);
            if (bit_end) begin
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bidx == BW'(DATA_W - 1)) begin
                            bidx  <= '0;
                            state <= par_en ? ST_PAR : ST_STOP;
                        end else begin
                            bidx <= bidx + BW'(1);
                        end
                    end
                    ST_PAR:  state <= ST_STOP;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R8: a character only begins when the gate was open.
    a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(cts_block));
    // R4: the line changes only on tick edges.
    a_r4_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));

endmodule

// File: rtl/fu_rx.sv
// Serial receiver. Synchronises rxd, detects a start on a tick once the line
// has been seen high, confirms it 8 ticks later, then samples each following
// bit mid-cell. Emits a one-clock push with {parity err, framing err, data}.
module fu_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              push,
    output logic [DATA_W+1:0] push_data
);
    import fifo_uart_pkg::*;
    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);

    ser_state_t        state;
    logic [1:0]        sync;
    logic              rxd_s;
    logic              armed;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] shreg;
    logic              perr;
    logic              mid_start, bit_end;

    // Sample-point decode.
    always_comb begin
        rxd_s     = sync[1];
        mid_start = tick && (tcnt == TW'(OSR / 2 - 1));
        bit_end   = tick && (tcnt == TW'(OSR - 1));
    end

    // Two-flop synchroniser for the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    // Frame sequencing and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            armed     <= 1'b0;
            tcnt      <= '0;
            bidx      <= '0;
            shreg     <= '0;
            perr      <= 1'b0;
            push      <= 1'b0;
            push_data <= '0;
        end else begin
            push <= 1'b0;
            case (state)
                ST_IDLE: begin
                    tcnt <= '0;
                    bidx <= '0;
                    if (tick && armed && !rxd_s) begin
                        state <= ST_START;
                        armed <= 1'b0;
                        perr  <= 1'b0;
                    end else if (rxd_s) begin
                        armed <= 1'b1;
                    end
                end
                ST_START: if (tick) begin
                    if (mid_start) begin
                        tcnt  <= '0;
                        state <= rxd_s ? ST_IDLE : ST_DATA;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                ST_DATA: if (tick) begin
                    tcnt <= bit_end ? '0 : tcnt + TW'(1);
                    if (bit_end) begin
                        shreg <= {rxd_s, shreg[DATA_W-1:1]};
                        if (bidx == BW'(DATA_W - 1)) begin
                            bidx  <= '0;
                            state <= par_en ? ST_PAR : ST_STOP;
                        end else begin
                            bidx <= bidx + BW'(1);
                        end
                    end
                end
                ST_PAR: if (tick) begin
                    tcnt <= bit_end ? '0 : tcnt + TW'(1);
                    if (bit_end) begin
                        perr  <= rxd_s ^ (^shreg) ^ par_odd;
                        state <= ST_STOP;
                    end
                end
                default: if (tick) begin
                    tcnt <= bit_end ? '0 : tcnt + TW'(1);
                    if (bit_end) begin
                        push      <= 1'b1;
                        push_data <= {perr, !rxd_s, shreg};
                        state     <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R9: a start seen high at its midpoint returns to idle without a byte.
    a_r9_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && mid_start && rxd_s) |=> (state == ST_IDLE && !push));
    // R10: a byte is only emitted on leaving the stop bit.
    a_r10_push_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ($past(state) == ST_STOP && state == ST_IDLE));

endmodule

// File: rtl/fifo_uart.sv
// Top of the buffered serial port. Joins the tick generator, both queues and
// both shifters; synchronises cts_n; keeps the sticky loss flags; derives the
// receive interrupt and the automatic request-to-send from the receive level.
module fifo_uart #(
    parameter int DEPTH  = 16,
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4,
    localparam int DATA_W = 8,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_frame_err,
    output logic              rd_parity_err,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [FRAC_W-1:0] cfg_frac_add,
    input  logic [FRAC_W-1:0] cfg_frac_mul,
    input  logic [1:0]        cfg_trig,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_auto_cts,
    input  logic              cfg_auto_rts,
    output logic              txd,
    input  logic              rxd,
    output logic              rts_n,
    input  logic              cts_n,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_empty,
    output logic [CW-1:0]     rx_level,
    output logic              tx_overflow,
    output logic              rx_overrun,
    output logic              irq_rx
);
    import fifo_uart_pkg::*;

    logic              tick;
    logic              tx_pop, tx_drop, tx_busy;
    logic [DATA_W-1:0] tx_head;
    logic [CW-1:0]     tx_level;
    logic              rx_push, rx_full, rx_drop;
    logic [DATA_W+1:0] rx_word, rx_head;
    logic [1:0]        cts_sync;
    logic              at_trig;

    fu_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(cfg_div),
        .frac_add(cfg_frac_add), .frac_mul(cfg_frac_mul), .tick(tick)
    );

    fu_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty),
        .level(tx_level), .drop(tx_drop)
    );

    fu_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .q_empty(tx_empty),
        .q_data(tx_head), .par_en(cfg_parity_en), .par_odd(cfg_parity_odd),
        .cts_block(cfg_auto_cts && cts_sync[1]), .q_pop(tx_pop),
        .txd(txd), .busy(tx_busy)
    );

    fu_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .par_en(cfg_parity_en), .par_odd(cfg_parity_odd),
        .push(rx_push), .push_data(rx_word)
    );

    fu_fifo #(.WIDTH(DATA_W + 2), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
        .pop(rd_en), .head(rx_head), .full(rx_full), .empty(rx_empty),
        .level(rx_level), .drop(rx_drop)
    );

    // Read-port fields and threshold comparison.
    always_comb begin
        rd_data       = rx_head[DATA_W-1:0];
        rd_frame_err  = rx_head[DATA_W];
        rd_parity_err = rx_head[DATA_W+1];
        at_trig       = (rx_level >= CW'(trig_level(cfg_trig)));
        irq_rx        = at_trig;
    end

    // Synchronise cts_n (idle = not ready) and keep sticky loss flags and RTS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_sync    <= 2'b11;
            tx_overflow <= 1'b0;
            rx_overrun  <= 1'b0;
            rts_n       <= 1'b0;
        end else begin
            cts_sync <= {cts_sync[0], cts_n};
            if (tx_drop) tx_overflow <= 1'b1;
            if (rx_drop) rx_overrun  <= 1'b1;
            rts_n <= cfg_auto_rts && at_trig;
        end
    end

    // R7: automatic RTS follows the receive level one clock later.
    a_r7_rts_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_rts && rx_level >= CW'(trig_level(cfg_trig))) |=> rts_n);
    // R7: with automatic RTS off, the line stays asserted.
    a_r7_rts_manual: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_auto_rts |=> !rts_n);
    // R2: the overflow flag, once set, stays set.
    a_r2_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_overflow) |-> tx_overflow);
    // R8: the transmitter does not leave idle while the queue is empty.
    a_r8_no_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_empty) && !$past(tx_busy)) |-> !tx_busy || $past(tx_level) != '0);

endmodule

// File: tb/fifo_uart_test.sv
module fifo_uart_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_frame_err, rd_parity_err;
    logic [15:0] cfg_div = 16'd1;
    logic [3:0] cfg_frac_add = '0, cfg_frac_mul = '0;
    logic [1:0] cfg_trig = '0;
    logic       cfg_parity_en = 0, cfg_parity_odd = 0, cfg_auto_cts = 0, cfg_auto_rts = 0;
    logic       txd, rts_n, cts_n = 1'b0;
    logic       tx_full, tx_empty, rx_empty, tx_overflow, rx_overrun, irq_rx;
    logic [4:0] rx_level;
    logic       loop_en = 1'b1, rx_drv = 1'b1;
    wire        rxd_w = loop_en ? txd : rx_drv;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    fifo_uart uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_frame_err(rd_frame_err), .rd_parity_err(rd_parity_err),
        .cfg_div(cfg_div), .cfg_frac_add(cfg_frac_add), .cfg_frac_mul(cfg_frac_mul),
        .cfg_trig(cfg_trig), .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_auto_cts(cfg_auto_cts), .cfg_auto_rts(cfg_auto_rts), .txd(txd), .rxd(rxd_w),
        .rts_n(rts_n), .cts_n(cts_n), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_empty(rx_empty), .rx_level(rx_level), .tx_overflow(tx_overflow),
        .rx_overrun(rx_overrun), .irq_rx(irq_rx)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0; rd_en = 0; cfg_div = 16'd1; cfg_frac_add = 0; cfg_frac_mul = 0;
        cfg_trig = 0; cfg_parity_en = 0; cfg_parity_odd = 0; cfg_auto_cts = 0;
        cfg_auto_rts = 0; cts_n = 0; loop_en = 1; rx_drv = 1;
        wait_clk(4);
        rst_n = 1;
        wait_clk(2);
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_en = 1; wr_data = b;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pop_check(input string req, input logic [7:0] d, input logic fe, input logic pe);
        check_eq(req, "rd_data", rd_data, d);
        check_eq(req, "rd_frame_err", rd_frame_err, fe);
        check_eq(req, "rd_parity_err", rd_parity_err, pe);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic wait_txd_low();
        while (txd) @(negedge clk);
    endtask

    // R1: reset values
    task automatic t_reset();
        do_reset();
        check_eq("R1", "txd", txd, 1);
        check_eq("R1", "rts_n", rts_n, 0);
        check_eq("R1", "tx_empty", tx_empty, 1);
        check_eq("R1", "rx_empty", rx_empty, 1);
        check_eq("R1", "rx_level", rx_level, 0);
        check_eq("R1", "flags", {tx_overflow, rx_overrun, irq_rx}, 0);
    endtask

    // R4: serial layout on txd, sampled mid-bit
    task automatic t_tx_frame(input logic [7:0] d, input logic pen, input logic odd);
        do_reset();
        loop_en = 0; cfg_parity_en = pen; cfg_parity_odd = odd;
        write_byte(d);
        wait_txd_low();
        wait_clk(8);
        check_eq("R4", "start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
            wait_clk(16);
            check_eq("R4", $sformatf("data bit %0d", i), txd, d[i]);
        end
        if (pen) begin
            wait_clk(16);
            check_eq("R4", "parity bit", txd, (^d) ^ odd);
        end
        wait_clk(16);
        check_eq("R4", "stop bit", txd, 1);
        wait_clk(20);
    endtask

    // R5: start bit length in clocks for a given tick configuration
    task automatic t_baud(input int dv, input int add, input int mul, input int exp);
        int cnt;
        do_reset();
        loop_en = 0;
        cfg_div = 16'(dv); cfg_frac_add = 4'(add); cfg_frac_mul = 4'(mul);
        write_byte(8'hFF);
        wait_txd_low();
        cnt = 0;
        while (!txd) begin cnt++; @(negedge clk); end
        check_eq("R5", $sformatf("start length div=%0d add=%0d mul=%0d", dv, add, mul), cnt, exp);
        wait_clk(800);
    endtask

    task automatic drive_frame(input logic [7:0] d, input logic pen, input logic pbit, input logic stopb);
        loop_en = 0;
        rx_drv = 0; wait_clk(16);
        for (int i = 0; i < 8; i++) begin rx_drv = d[i]; wait_clk(16); end
        if (pen) begin rx_drv = pbit; wait_clk(16); end
        rx_drv = stopb; wait_clk(16);
        rx_drv = 1; wait_clk(32);
    endtask

    // R10: framing and parity errors stored with the byte
    task automatic t_rx_errors();
        do_reset();
        drive_frame(8'h5A, 0, 0, 1);
        pop_check("R10", 8'h5A, 0, 0);
        drive_frame(8'h3C, 0, 0, 0);
        pop_check("R10", 8'h3C, 1, 0);
        cfg_parity_en = 1;
        drive_frame(8'h07, 1, 0, 1);
        pop_check("R10", 8'h07, 0, 1);
        drive_frame(8'h07, 1, 1, 1);
        pop_check("R10", 8'h07, 0, 0);
        check_eq("R10", "rx_empty after reads", rx_empty, 1);
    endtask

    // R9: a short low pulse is not taken as a character
    task automatic t_glitch();
        do_reset();
        loop_en = 0;
        rx_drv = 0; wait_clk(4); rx_drv = 1;
        wait_clk(300);
        check_eq("R9", "rx_empty after glitch", rx_empty, 1);
        drive_frame(8'hC3, 0, 0, 1);
        pop_check("R9", 8'hC3, 0, 0);
    endtask

    // R2, R3, R8, R11: fill both queues, drop extras, drain in order
    task automatic t_fill();
        do_reset();
        cfg_auto_cts = 1; cts_n = 1;
        wait_clk(4);
        for (int i = 0; i < 17; i++) write_byte(8'(8'h30 + i));
        check_eq("R2", "tx_full", tx_full, 1);
        check_eq("R2", "tx_overflow", tx_overflow, 1);
        wait_clk(400);
        check_eq("R8", "txd held while cts_n high", txd, 1);
        check_eq("R8", "rx_level while blocked", rx_level, 0);
        cts_n = 0;
        wait_clk(16 * 180 + 300);
        check_eq("R2", "tx_empty after drain", tx_empty, 1);
        check_eq("R3", "rx_level full", rx_level, 16);
        check_eq("R3", "rx_overrun before extra", rx_overrun, 0);
        write_byte(8'hEE);
        wait_clk(300);
        check_eq("R3", "rx_overrun", rx_overrun, 1);
        check_eq("R3", "rx_level held", rx_level, 16);
        for (int i = 0; i < 16; i++) pop_check("R11", 8'(8'h30 + i), 0, 0);
        check_eq("R11", "rx_empty", rx_empty, 1);
        rd_en = 1; @(negedge clk); rd_en = 0;
        check_eq("R11", "level after empty read", rx_level, 0);
    endtask

    // R8: a character in progress completes after cts_n rises
    task automatic t_cts_mid();
        do_reset();
        cfg_auto_cts = 1;
        write_byte(8'h11);
        write_byte(8'h22);
        wait_txd_low();
        cts_n = 1;
        wait_clk(400);
        check_eq("R8", "first char completed", rx_level, 1);
        check_eq("R8", "second char held", tx_empty, 0);
        check_eq("R8", "line idle", txd, 1);
        cts_n = 0;
        wait_clk(250);
        check_eq("R8", "second char sent", rx_level, 2);
        pop_check("R8", 8'h11, 0, 0);
        pop_check("R8", 8'h22, 0, 0);
    endtask

    // R6, R7: threshold codes drive irq_rx and automatic rts_n
    task automatic t_trigger();
        do_reset();
        cfg_auto_rts = 1; cfg_trig = 2'b01;
        for (int i = 0; i < 3; i++) write_byte(8'(8'h50 + i));
        wait_clk(3 * 180 + 100);
        check_eq("R7", "rts_n below threshold", rts_n, 0);
        check_eq("R6", "irq below 4", irq_rx, 0);
        write_byte(8'h53);
        wait_clk(250);
        check_eq("R7", "rts_n at threshold", rts_n, 1);
        check_eq("R6", "irq at 4", irq_rx, 1);
        pop_check("R7", 8'h50, 0, 0);
        @(negedge clk);
        check_eq("R7", "rts_n after read", rts_n, 0);
        check_eq("R6", "irq at 3 of 4", irq_rx, 0);
        cfg_trig = 2'b00; #1;
        check_eq("R6", "irq code 00", irq_rx, 1);
        cfg_trig = 2'b10; #1;
        check_eq("R6", "irq code 10", irq_rx, 0);
        cfg_trig = 2'b11; #1;
        check_eq("R6", "irq code 11", irq_rx, 0);
        cfg_auto_rts = 0; cfg_trig = 2'b00;
        wait_clk(2);
        check_eq("R7", "rts_n manual", rts_n, 0);
    endtask

    initial begin
        t_reset();
        t_tx_frame(8'hA5, 0, 0);
        t_tx_frame(8'hA5, 1, 0);
        t_tx_frame(8'h03, 1, 1);
        t_baud(3, 0, 0, 48);
        t_baud(2, 1, 2, 40);
        t_baud(0, 0, 0, 16);
        t_baud(2, 3, 2, 32);
        t_rx_errors();
        t_glitch();
        t_fill();
        t_cts_mid();
        t_trigger();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule